// File: doc/BRIEF.md
# Decode-Stage Interlock Unit

This control block sits beside the decode stage of a five-stage in-order pipeline: fetch, decode with operand read, execute, memory, writeback. The pipeline has no operand bypass. A source operand can only be taken from the register file, which reads without a clock and writes on the clock edge at the end of writeback. Each cycle the unit compares the register indices that the decoding instruction reads against the destinations of the older instructions still in flight. If any source is not yet written, the unit holds decode and fetch and sends a no-op into execute.

The unit keeps its own record of in-flight destinations. An instruction that leaves decode with a live destination goes into the execute slot of that record. The record then advances one stage per clock, and the entry is dropped after writeback. A stalled instruction does not enter the record; a bubble goes in its place. The depth of the record is a parameter. Its default of three covers execute, memory and writeback, so a consumer directly behind its producer waits three cycles.

Top module: `pipe_interlock`

## Requirements
- R1: After a synchronous active-high reset the record of in-flight destinations is empty, and no stall is raised for any decode instruction until a new producer issues.
- R2: A consumer that reads source A (`dec_srca`, `dec_srca_en`=1) equal to the destination of the instruction issued in the previous cycle is held exactly 3 cycles and issues in the 4th.
- R3: The same 3-cycle hold applies when the match is on source B (`dec_srcb`, `dec_srcb_en`=1).
- R4: Each unrelated instruction issued between producer and consumer shortens the hold by one cycle: one gap gives 2, two gaps give 1, three gaps give 0.
- R5: Source index 0 is the constant-zero register and never causes a stall, even if an older instruction names index 0 as its destination with write enable set.
- R6: An older instruction with `dec_dst_we`=0 (store, branch) is never treated as a producer.
- R7: A source whose enable bit is 0 is never compared, even if its index matches an in-flight destination.
- R8: `stall_fetch`, `stall_decode` and `bubble_ex` are equal in every cycle.
- R9: When `dec_valid`=0, no stall is raised, whatever the source fields hold.
- R10: When both sources are pending from different producers, the hold lasts until the later of the two has written back.
- R11: A held instruction enters the record only in the cycle it issues, so its own consumers see the full 3-cycle hold counted from that cycle.
- R12: A reset asserted while a hold is active clears the record, and the hold is gone in the first cycle after the reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dec_valid | input | 1 | Decode stage holds a real instruction |
| dec_srca | input | IDX_W | Source A register index |
| dec_srca_en | input | 1 | Source A is read by the instruction |
| dec_srcb | input | IDX_W | Source B register index |
| dec_srcb_en | input | 1 | Source B is read by the instruction |
| dec_dst | input | IDX_W | Destination register index of the decode instruction |
| dec_dst_we | input | 1 | Decode instruction writes its destination |
| stall_fetch | output | 1 | Hold the fetch stage |
| stall_decode | output | 1 | Hold the decode stage |
| bubble_ex | output | 1 | Put a no-op with write enable cleared into execute |

## Verification
The three outputs are combinational. Each is due in the same cycle as the decode fields that cause it, and it reflects the record as it stood after the most recent rising edge. An issue therefore affects the outputs from the next cycle onward. With the default depth, a producer issued in cycle k blocks its consumers in cycles k+1 to k+3. The bench drives inputs on the falling edge and samples 1 ns later. It advances a behavioural model at the rising edge: a per-register "readable from cycle" number, set to k+4 on issue. Every cycle it compares all three outputs with that model, and it counts the hold cycles of each consumer against the figure given in its requirement.

// File: rtl/pipe_ilk_pkg.sv
package pipe_ilk_pkg;
    // Register index width of the default configuration.
    localparam int REG_IDX_W    = 5;
    // Stages an issued producer spends before its result is readable
    // (execute, memory, writeback).
    localparam int TRACK_STAGES = 3;
    // Source operands per instruction.
    localparam int NUM_SRC      = 2;
endpackage

// File: rtl/ilk_dest_track.sv
module ilk_dest_track #(
    parameter int IDX_W = 5,
    parameter int DEPTH = 3
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        push_vld,
    input  logic [IDX_W-1:0]            push_idx,
    output logic [DEPTH-1:0]            slot_vld,
    output logic [DEPTH-1:0][IDX_W-1:0] slot_idx
);
    typedef struct packed {
        logic [DEPTH-1:0]            vld;
        logic [DEPTH-1:0][IDX_W-1:0] idx;
    } track_t;

    track_t trk_d, trk_q;

    // Slot 0 is the execute stage; the record never stalls downstream.
    always_comb begin
        trk_d        = trk_q;
        trk_d.vld[0] = push_vld;
        trk_d.idx[0] = push_idx;
        for (int s = 1; s < DEPTH; s++) begin
            trk_d.vld[s] = trk_q.vld[s-1];
            trk_d.idx[s] = trk_q.idx[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    assign slot_vld = trk_q.vld;
    assign slot_idx = trk_q.idx;
endmodule

// File: rtl/ilk_src_match.sv
module ilk_src_match #(
    parameter int IDX_W = 5,
    parameter int DEPTH = 3
) (
    input  logic                        src_en,
    input  logic [IDX_W-1:0]            src_idx,
    input  logic [DEPTH-1:0]            slot_vld,
    input  logic [DEPTH-1:0][IDX_W-1:0] slot_idx,
    output logic                        pending
);
    logic [DEPTH-1:0] hit_vec;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        assign hit_vec[g] = slot_vld[g] && (slot_idx[g] == src_idx);
    end

    // Index zero reads a constant, so it is always ready.
    assign pending = src_en && (src_idx != '0) && (|hit_vec);
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
    import pipe_ilk_pkg::*;
#(
    parameter int IDX_W = REG_IDX_W,
    parameter int TRACK = TRACK_STAGES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dec_valid,
    input  logic [IDX_W-1:0] dec_srca,
    input  logic             dec_srca_en,
    input  logic [IDX_W-1:0] dec_srcb,
    input  logic             dec_srcb_en,
    input  logic [IDX_W-1:0] dec_dst,
    input  logic             dec_dst_we,
    output logic             stall_fetch,
    output logic             stall_decode,
    output logic             bubble_ex
);
    logic [TRACK-1:0]            slot_vld;
    logic [TRACK-1:0][IDX_W-1:0] slot_idx;
    logic [NUM_SRC-1:0]          src_en;
    logic [NUM_SRC-1:0][IDX_W-1:0] src_idx;
    logic [NUM_SRC-1:0]          src_pend;
    logic                        hold;
    logic                        push_vld;

    assign src_en[0]  = dec_srca_en;
    assign src_idx[0] = dec_srca;
    assign src_en[1]  = dec_srcb_en;
    assign src_idx[1] = dec_srcb;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        ilk_src_match #(.IDX_W(IDX_W), .DEPTH(TRACK)) u_match (
            .src_en  (src_en[g]),
            .src_idx (src_idx[g]),
            .slot_vld(slot_vld),
            .slot_idx(slot_idx),
            .pending (src_pend[g])
        );
    end

    assign hold     = dec_valid && (|src_pend);
    // Only an issuing instruction with a live, non-zero destination is tracked.
    assign push_vld = dec_valid && !hold && dec_dst_we && (dec_dst != '0);

    ilk_dest_track #(.IDX_W(IDX_W), .DEPTH(TRACK)) u_track (
        .clk     (clk),
        .rst     (rst),
        .push_vld(push_vld),
        .push_idx(dec_dst),
        .slot_vld(slot_vld),
        .slot_idx(slot_idx)
    );

    assign stall_fetch  = hold;
    assign stall_decode = hold;
    assign bubble_ex    = hold;
endmodule

// File: rtl/pipe_interlock_chk.sv
module pipe_interlock_chk #(
    parameter int IDX_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             dec_valid,
    input logic [IDX_W-1:0] dec_srca,
    input logic             dec_srca_en,
    input logic [IDX_W-1:0] dec_srcb,
    input logic             dec_srcb_en,
    input logic [IDX_W-1:0] dec_dst,
    input logic             dec_dst_we,
    input logic             stall_fetch,
    input logic             stall_decode,
    input logic             bubble_ex
);
    a_r8_outputs_agree: assert property (@(posedge clk) disable iff (rst)
        (stall_fetch == stall_decode) && (bubble_ex == stall_decode));

    a_r9_idle_no_stall: assert property (@(posedge clk) disable iff (rst)
        !dec_valid |-> !stall_decode);

    a_r5_r7_nothing_read: assert property (@(posedge clk) disable iff (rst)
        ((!dec_srca_en || dec_srca == '0) && (!dec_srcb_en || dec_srcb == '0))
        |-> !stall_decode);

    a_r1_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !stall_decode);

    a_r2_back_to_back_holds: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_srca_en && dec_srca != '0 && !$past(rst) &&
         $past(dec_valid && !stall_decode && dec_dst_we) &&
         dec_srca == $past(dec_dst)) |-> stall_decode);

    a_r3_back_to_back_holds: assert property (@(posedge clk) disable iff (rst)
        (dec_valid && dec_srcb_en && dec_srcb != '0 && !$past(rst) &&
         $past(dec_valid && !stall_decode && dec_dst_we) &&
         dec_srcb == $past(dec_dst)) |-> stall_decode);
endmodule

bind pipe_interlock pipe_interlock_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/pipe_interlock_test.sv
module pipe_interlock_test;
    localparam int IW  = 5;
    localparam int LAT = 4; // issue cycle + 3 tracked stages

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic dec_valid = 1'b0;
    logic [IW-1:0] dec_srca = '0, dec_srcb = '0, dec_dst = '0;
    logic dec_srca_en = 1'b0, dec_srcb_en = 1'b0, dec_dst_we = 1'b0;
    logic stall_fetch, stall_decode, bubble_ex;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int ready_at [0:31];
    bit issued = 0;

    always #2.5 clk = ~clk;

    pipe_interlock uut (
        .clk(clk), .rst(rst), .dec_valid(dec_valid),
        .dec_srca(dec_srca), .dec_srca_en(dec_srca_en),
        .dec_srcb(dec_srcb), .dec_srcb_en(dec_srcb_en),
        .dec_dst(dec_dst), .dec_dst_we(dec_dst_we),
        .stall_fetch(stall_fetch), .stall_decode(stall_decode), .bubble_ex(bubble_ex)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit model_stall();
        bit a, b;
        a = dec_srca_en && dec_srca != 0 && ready_at[dec_srca] > cyc;
        b = dec_srcb_en && dec_srcb != 0 && ready_at[dec_srcb] > cyc;
        return dec_valid && (a || b);
    endfunction

    // Compare the outputs with the model in the current cycle.
    task automatic sample(input string req);
        bit e;
        #1;
        e = model_stall();
        chk(stall_decode == e, req, stall_decode, e);
        chk(stall_fetch == stall_decode && bubble_ex == stall_decode, "R8",
            {stall_fetch, stall_decode, bubble_ex}, {3{stall_decode}});
        issued = dec_valid && !e;
    endtask

    task automatic tick();
        @(posedge clk);
        if (rst) begin
            for (int r = 0; r < 32; r++) ready_at[r] = 0;
        end else if (issued && dec_dst_we && dec_dst != 0) begin
            ready_at[dec_dst] = cyc + LAT;
        end
        cyc++;
        @(negedge clk);
    endtask

    task automatic drive(input bit v, input int a, input bit ae, input int b,
                         input bit be, input int d, input bit we);
        dec_valid = v; dec_srca = IW'(a); dec_srca_en = ae;
        dec_srcb = IW'(b); dec_srcb_en = be; dec_dst = IW'(d); dec_dst_we = we;
    endtask

    // Present one instruction until it issues; return the hold cycles.
    task automatic send(input string req, input bit v, input int a, input bit ae,
                        input int b, input bit be, input int d, input bit we,
                        output int held);
        held = 0;
        drive(v, a, ae, b, be, d, we);
        for (int k = 0; k < 20; k++) begin
            sample(req);
            tick();
            if (!issued && v) held++;
            else break;
        end
    endtask

    task automatic filler();
        int h;
        send("R4", 1, 0, 0, 0, 0, 0, 0, h);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired (all requirements)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int h;
        for (int r = 0; r < 32; r++) ready_at[r] = 0;
        @(negedge clk);
        tick();                        // first edge loads the reset state
        sample("R1"); tick();
        rst = 1'b0;

        // R1: nothing in flight, a reader passes straight through
        send("R1", 1, 5, 1, 6, 1, 0, 0, h);
        chk(h == 0, "R1 hold after reset", h, 0);

        // R2: back-to-back on source A
        send("R2", 1, 0, 0, 0, 0, 5, 1, h);
        send("R2", 1, 5, 1, 0, 0, 0, 0, h);
        chk(h == 3, "R2 hold srcA", h, 3);

        // R3: back-to-back on source B
        send("R3", 1, 0, 0, 0, 0, 7, 1, h);
        send("R3", 1, 1, 1, 7, 1, 0, 0, h);
        chk(h == 3, "R3 hold srcB", h, 3);

        // R4: gaps of one, two and three
        for (int gap = 1; gap <= 3; gap++) begin
            send("R4", 1, 0, 0, 0, 0, 9, 1, h);
            for (int f = 0; f < gap; f++) filler();
            send("R4", 1, 9, 1, 0, 0, 0, 0, h);
            chk(h == 3 - gap, "R4 hold with gap", h, 3 - gap);
        end

        // R5: index zero never pending
        send("R5", 1, 0, 0, 0, 0, 0, 1, h);
        send("R5", 1, 0, 1, 0, 1, 0, 0, h);
        chk(h == 0, "R5 zero source", h, 0);

        // R6: no write enable, no producer
        send("R6", 1, 0, 0, 0, 0, 11, 0, h);
        send("R6", 1, 11, 1, 11, 1, 0, 0, h);
        chk(h == 0, "R6 non-writing older", h, 0);

        // R7: unused sources are not compared
        send("R7", 1, 0, 0, 0, 0, 12, 1, h);
        send("R7", 1, 12, 0, 12, 0, 0, 0, h);
        chk(h == 0, "R7 disabled sources", h, 0);

        // R9: invalid decode slot with a matching source
        send("R9", 1, 0, 0, 0, 0, 13, 1, h);
        send("R9", 0, 13, 1, 13, 1, 0, 0, h);
        chk(h == 0 && !stall_decode, "R9 idle decode", h, 0);
        filler(); filler(); filler();

        // R10 and R11: two producers, consumer also produces
        send("R10", 1, 0, 0, 0, 0, 3, 1, h);
        send("R10", 1, 0, 0, 0, 0, 4, 1, h);
        send("R10", 1, 3, 1, 4, 1, 6, 1, h);
        chk(h == 3, "R10 later of two producers", h, 3);
        send("R11", 1, 6, 1, 0, 0, 0, 0, h);
        chk(h == 3, "R11 held producer tracked from issue", h, 3);

        // R12: reset during a hold
        send("R12", 1, 0, 0, 0, 0, 8, 1, h);
        drive(1, 8, 1, 0, 0, 0, 0);
        sample("R12");
        chk(stall_decode == 1'b1, "R12 hold before reset", stall_decode, 1);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        sample("R12");
        chk(stall_decode == 1'b0, "R12 hold cleared by reset", stall_decode, 0);
        tick();

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule